// File: doc/BRIEF.md
# Interruption PSW Swap Controller

This block keeps the 128-bit program-status word (PSW) of a small processor and performs the hardware side of taking an interruption. The low 64 bits of the PSW hold the instruction address. The upper 64 bits hold the condition code and the other control fields, and this block carries them through unchanged. A sequential-advance input adds an instruction length to the address. A branch input replaces the address with a target.

Twelve 128-bit slots live inside the block, two for each of six interruption classes. One slot of each pair receives the interrupted PSW. The other holds the handler PSW, which privileged software writes ahead of time through a slot-write port. When a request is accepted, the block stores the current PSW into that class's save slot on the first edge. On the next edge it loads the class's handler PSW, whatever that slot contains. A load-PSW command can later copy any slot back into the PSW, so the handler resumes the interrupted program by naming the save slot.

Top module: `pswSwapUnit`

## Requirements
- R1: While reset is held low, and on the first cycle after it, `psw` is all zero, `busy` and `takenPulse` are low, and every slot reads as zero.
- R2: `advValid` adds `advLen` (2, 4 or 6) to `psw[63:0]` on the next edge, modulo 2^64, and leaves `psw[127:64]` unchanged.
- R3: `brValid` replaces `psw[63:0]` with `brTarget` and keeps `psw[127:64]`. When branch and advance arrive together, the branch wins.
- R4: Class codes are restart 0, supervisor-call 1, external 2, I/O 3, machine-check 4 and program 5, and `intReq[k]` requests class k. Class k stores to slot 2k and loads from slot 2k+1. On the edge that accepts a request, the current PSW is written to slot 2k. On the following edge, `psw` becomes the contents of slot 2k+1.
- R5: When several `intReq` bits are set together, exactly one class is taken, chosen in this order: machine-check, program, supervisor-call, external, I/O, restart.
- R6: `busy` is high for exactly the one cycle between the store edge and the load edge. Interruption, load-PSW, branch and advance inputs presented while `busy` is high are ignored. On the accepting cycle itself, load-PSW, branch and advance are also ignored.
- R7: `takenPulse` is high for one cycle with `takenClass` equal to the accepted class code. That cycle is the first one in which the handler PSW is visible on `psw`.
- R8: `lpswValid` copies slot `lpswSlot` (0 to 11) into `psw` on the next edge. It takes precedence over branch and advance.
- R9: `slotWrEn` writes `slotWrData` into slot `slotWrAddr` on the edge. If an accepted interruption stores its old PSW to that same slot on that edge, the stored PSW is kept. A read on the same edge sees the slot's previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intReq | input | 6 | Interruption request, one bit per class code |
| advValid | input | 1 | Sequential advance request |
| advLen | input | 3 | Instruction length to add |
| brValid | input | 1 | Taken-branch request |
| brTarget | input | 64 | Branch target address |
| lpswValid | input | 1 | Load-PSW command |
| lpswSlot | input | 4 | Slot to load from |
| slotWrEn | input | 1 | Software slot write enable |
| slotWrAddr | input | 4 | Slot to write |
| slotWrData | input | 128 | PSW value to write |
| psw | output | 128 | Current PSW |
| busy | output | 1 | Swap in progress |
| takenPulse | output | 1 | Interruption taken this cycle |
| takenClass | output | 3 | Class code of the taken interruption |

## Verification
The directed part loads a distinct handler PSW for each class. It then branches to the top of the address space and advances, which separates modular wraparound from saturation or carry into the control half. It raises all six requests at once to expose the priority order, and it drives branch, advance, load and new requests during the busy cycle to show they are dropped. A software write aimed at a slot that is saved on the same edge shows which write wins, and a later load-PSW from that slot reads the value back. Random cycles then mix sparse interruptions, frequent advances and branches, load-PSW commands and slot writes, so that save, handler-load and restore interleave in orders the directed cases do not reach.

// File: rtl/pswSwapPkg.sv
package pswSwapPkg;
  localparam int NUM_CLASS = 6;
  localparam int CLS_W     = 3;
  localparam int SLOT_W    = CLS_W + 1;
  localparam int NUM_SLOT  = 2 * NUM_CLASS;

  typedef enum logic [CLS_W-1:0] {
    CLS_RESTART = 3'd0,
    CLS_SVC     = 3'd1,
    CLS_EXT     = 3'd2,
    CLS_IO      = 3'd3,
    CLS_MCHK    = 3'd4,
    CLS_PROG    = 3'd5
  } intClass_e;

  // highest priority first
  localparam logic [CLS_W-1:0] PRIO_ORDER [NUM_CLASS] = '{3'd4, 3'd5, 3'd1, 3'd2, 3'd3, 3'd0};

  typedef struct packed {
    logic             storeOld;
    logic             loadNew;
    logic             doLpsw;
    logic             doBranch;
    logic             doAdv;
    logic [CLS_W-1:0] cls;
  } pswStrobe_t;

  function automatic logic [CLS_W-1:0] pickClass(input logic [NUM_CLASS-1:0] req);
    logic [CLS_W-1:0] r;
    r = '0;
    for (int i = NUM_CLASS - 1; i >= 0; i--) begin
      if (req[PRIO_ORDER[i]]) r = PRIO_ORDER[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/pswSwapCtrl.sv
module pswSwapCtrl
  import pswSwapPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CLASS-1:0] intReq,
  input  logic                 advValid,
  input  logic                 brValid,
  input  logic                 lpswValid,
  output pswStrobe_t           strobe,
  output logic                 busy,
  output logic                 takenPulse,
  output logic [CLS_W-1:0]     takenClass
);
  typedef enum logic {ST_IDLE, ST_LOAD} swapState_e;

  swapState_e       state;
  logic [CLS_W-1:0] pendCls;
  logic             idle;
  logic             accept;
  logic             freeRun;
  logic [CLS_W-1:0] picked;

  assign idle    = (state == ST_IDLE);
  assign accept  = idle && (|intReq);
  assign freeRun = idle && !accept;
  assign picked  = pickClass(intReq);
  assign busy    = (state == ST_LOAD);

  always_comb begin
    strobe          = '0;
    strobe.storeOld = accept;
    strobe.loadNew  = busy;
    strobe.cls      = accept ? picked : pendCls;
    strobe.doLpsw   = freeRun && lpswValid;
    strobe.doBranch = freeRun && !lpswValid && brValid;
    strobe.doAdv    = freeRun && !lpswValid && !brValid && advValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pendCls    <= '0;
      takenPulse <= 1'b0;
      takenClass <= '0;
    end else begin
      takenPulse <= busy;
      if (busy) takenClass <= pendCls;
      if (accept) begin
        state   <= ST_LOAD;
        pendCls <= picked;
      end else begin
        state <= ST_IDLE;
      end
    end
  end

  // R6
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R7
  taken_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (takenPulse && takenClass == $past(strobe.cls)));

  // R8
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.storeOld, strobe.loadNew, strobe.doLpsw, strobe.doBranch, strobe.doAdv}));

  // R5
  mchk_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeOld && intReq[CLS_MCHK]) |-> (strobe.cls == CLS_MCHK));
endmodule

// File: rtl/pswSwapDatapath.sv
module pswSwapDatapath
  import pswSwapPkg::*;
#(
  parameter int PSW_W = 128,
  parameter int IA_W  = 64,
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pswStrobe_t        strobe,
  input  logic [LEN_W-1:0]  advLen,
  input  logic [IA_W-1:0]   brTarget,
  input  logic [SLOT_W-1:0] lpswSlot,
  input  logic              slotWrEn,
  input  logic [SLOT_W-1:0] slotWrAddr,
  input  logic [PSW_W-1:0]  slotWrData,
  output logic [PSW_W-1:0]  pswQ
);
  logic [PSW_W-1:0]  slotMem [NUM_SLOT];
  logic [SLOT_W-1:0] oldIdx;
  logic [SLOT_W-1:0] rdIdx;
  logic [PSW_W-1:0]  rdData;
  logic [PSW_W-1:0]  pswD;
  logic              swWrite;

  assign oldIdx  = {strobe.cls, 1'b0};
  assign rdIdx   = strobe.loadNew ? {strobe.cls, 1'b1} : lpswSlot;
  assign rdData  = (32'(rdIdx) < NUM_SLOT) ? slotMem[rdIdx] : '0;
  assign swWrite = slotWrEn && (32'(slotWrAddr) < NUM_SLOT)
                   && !(strobe.storeOld && slotWrAddr == oldIdx);

  always_comb begin
    pswD = pswQ;
    if (strobe.loadNew || strobe.doLpsw) pswD = rdData;
    else if (strobe.doBranch)            pswD[IA_W-1:0] = brTarget;
    else if (strobe.doAdv)               pswD[IA_W-1:0] = pswQ[IA_W-1:0] + IA_W'(advLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pswQ <= '0;
      for (int i = 0; i < NUM_SLOT; i++) slotMem[i] <= '0;
    end else begin
      pswQ <= pswD;
      if (strobe.storeOld) slotMem[oldIdx] <= pswQ;
      if (swWrite)         slotMem[slotWrAddr] <= slotWrData;
    end
  end

  // R6
  psw_idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadNew || strobe.doLpsw || strobe.doBranch || strobe.doAdv) |=> $stable(pswQ));

  // R2
  ctrl_half_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doAdv || strobe.doBranch) |=> (pswQ[PSW_W-1:IA_W] == $past(pswQ[PSW_W-1:IA_W])));
endmodule

// File: rtl/pswSwapUnit.sv
module pswSwapUnit
  import pswSwapPkg::*;
#(
  parameter int PSW_W = 128,
  parameter int IA_W  = 64,
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        intReq,
  input  logic              advValid,
  input  logic [LEN_W-1:0]  advLen,
  input  logic              brValid,
  input  logic [IA_W-1:0]   brTarget,
  input  logic              lpswValid,
  input  logic [3:0]        lpswSlot,
  input  logic              slotWrEn,
  input  logic [3:0]        slotWrAddr,
  input  logic [PSW_W-1:0]  slotWrData,
  output logic [PSW_W-1:0]  psw,
  output logic              busy,
  output logic              takenPulse,
  output logic [2:0]        takenClass
);
  pswStrobe_t strobe;

  pswSwapCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .intReq     (intReq),
    .advValid   (advValid),
    .brValid    (brValid),
    .lpswValid  (lpswValid),
    .strobe     (strobe),
    .busy       (busy),
    .takenPulse (takenPulse),
    .takenClass (takenClass)
  );

  pswSwapDatapath #(.PSW_W(PSW_W), .IA_W(IA_W), .LEN_W(LEN_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .advLen     (advLen),
    .brTarget   (brTarget),
    .lpswSlot   (lpswSlot),
    .slotWrEn   (slotWrEn),
    .slotWrAddr (slotWrAddr),
    .slotWrData (slotWrData),
    .pswQ       (psw)
  );
endmodule

// File: tb/sim_pswSwapUnit.sv
module sim_pswSwapUnit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [5:0]   intReq = '0;
  logic         advValid = 1'b0;
  logic [2:0]   advLen = 3'd2;
  logic         brValid = 1'b0;
  logic [63:0]  brTarget = '0;
  logic         lpswValid = 1'b0;
  logic [3:0]   lpswSlot = '0;
  logic         slotWrEn = 1'b0;
  logic [3:0]   slotWrAddr = '0;
  logic [127:0] slotWrData = '0;
  logic [127:0] psw;
  logic         busy;
  logic         takenPulse;
  logic [2:0]   takenClass;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [127:0] mMem [0:11];
  logic [127:0] mPsw = '0;
  logic         mBusy = 1'b0;
  logic [2:0]   mPend = '0;
  logic         mTaken = 1'b0;
  logic [2:0]   mTakenCls = '0;
  string        mTag = "R1";

  pswSwapUnit u0 (
    .clk(clk), .rstN(rstN), .intReq(intReq), .advValid(advValid), .advLen(advLen),
    .brValid(brValid), .brTarget(brTarget), .lpswValid(lpswValid), .lpswSlot(lpswSlot),
    .slotWrEn(slotWrEn), .slotWrAddr(slotWrAddr), .slotWrData(slotWrData),
    .psw(psw), .busy(busy), .takenPulse(takenPulse), .takenClass(takenClass)
  );

  always #10 clk = ~clk;

  function automatic logic [2:0] expPrio(input logic [5:0] r);
    if (r[4]) return 3'd4;
    if (r[5]) return 3'd5;
    if (r[1]) return 3'd1;
    if (r[2]) return 3'd2;
    if (r[3]) return 3'd3;
    return 3'd0;
  endfunction

  function automatic logic [127:0] rdSlot(input logic [3:0] a);
    return (a < 4'd12) ? mMem[a] : '0;
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: got %0d expected below 150000 cycles", cycles);
      finishRun();
    end
  end

  // model one edge using current inputs, then compare after the edge
  task automatic cyc(input string tag);
    logic [127:0] rdNew, rdL;
    logic [3:0]   skip;
    logic [2:0]   c;
    rdNew = mMem[{mPend, 1'b1}];
    rdL   = rdSlot(lpswSlot);
    skip  = 4'hF;
    mTaken = 1'b0;
    if (!mBusy && |intReq) begin
      c = expPrio(intReq);
      mMem[{c, 1'b0}] = mPsw;
      skip  = {c, 1'b0};
      mBusy = 1'b1;
      mPend = c;
      mTag  = "R4";
    end else if (mBusy) begin
      mPsw      = rdNew;
      mBusy     = 1'b0;
      mTaken    = 1'b1;
      mTakenCls = mPend;
      mTag      = (|intReq || brValid || advValid || lpswValid) ? "R6" : "R4";
    end else if (lpswValid) begin
      mPsw = rdL; mTag = "R8";
    end else if (brValid) begin
      mPsw[63:0] = brTarget; mTag = "R3";
    end else if (advValid) begin
      mPsw[63:0] = mPsw[63:0] + 64'(advLen); mTag = "R2";
    end else begin
      mTag = "R9";
    end
    if (slotWrEn && slotWrAddr < 4'd12 && slotWrAddr != skip) mMem[slotWrAddr] = slotWrData;
    @(posedge clk);
    @(negedge clk);
    chk((tag != "") ? tag : mTag, psw, mPsw);
    chk("R6 busy", {127'd0, busy}, {127'd0, mBusy});
    chk("R7 taken", {124'd0, takenPulse, (takenPulse ? takenClass : 3'd0)},
        {124'd0, mTaken, (mTaken ? mTakenCls : 3'd0)});
    intReq = '0; advValid = 1'b0; brValid = 1'b0; lpswValid = 1'b0; slotWrEn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 12; i++) mMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 psw", psw, '0);
    chk("R1 busy", {127'd0, busy}, '0);
    chk("R1 taken", {127'd0, takenPulse}, '0);
    rstN = 1'b1;
    // R1 slot read back via load-PSW after reset
    lpswValid = 1'b1; lpswSlot = 4'd5; cyc("R1 slot");

    // R9 load handler PSWs for every class
    for (int k = 0; k < 6; k++) begin
      slotWrEn = 1'b1; slotWrAddr = 4'(2 * k + 1);
      slotWrData = {32'hC0DE0000 + 32'(k), 32'h5A5A0000, 64'h1000 * 64'(k + 1)};
      cyc("R9");
    end
    // R8 give the control half a nonzero value
    slotWrEn = 1'b1; slotWrAddr = 4'd10; slotWrData = {64'hABCD_0000_1234_0000, 64'h40};
    cyc("R9");
    lpswValid = 1'b1; lpswSlot = 4'd10; brValid = 1'b1; brTarget = 64'h99; cyc("R8 over branch");
    // R3 branch to top, then R2 wraparound
    brValid = 1'b1; advValid = 1'b1; advLen = 3'd6; brTarget = 64'hFFFF_FFFF_FFFF_FFFE; cyc("R3 over adv");
    advValid = 1'b1; advLen = 3'd4; cyc("R2 wrap");
    // R5 all requests: machine-check wins; R6 inputs during busy dropped
    intReq = 6'b111111; brValid = 1'b1; brTarget = 64'h77; cyc("R5 store");
    intReq = 6'b111111; brValid = 1'b1; advValid = 1'b1; lpswValid = 1'b1; lpswSlot = 4'd1; cyc("R6 busy");
    chk("R5 class", {125'd0, takenClass}, {125'd0, 3'd4});
    // R8 restore interrupted PSW from slot 8
    lpswValid = 1'b1; lpswSlot = 4'd8; cyc("R8 restore");
    chk("R8 resumed", psw, {64'hABCD_0000_1234_0000, 64'h2});
    // R5 program over supervisor-call and I/O
    intReq = 6'b101010; cyc("R5");
    cyc("R5 load");
    chk("R5 prog", {125'd0, takenClass}, {125'd0, 3'd5});
    // R9 collision: svc store and software write to slot 2
    advValid = 1'b1; advLen = 3'd2; cyc("R2");
    intReq = 6'b000010; slotWrEn = 1'b1; slotWrAddr = 4'd2; slotWrData = {128{1'b1}}; cyc("R9 collide");
    cyc("R4 load");
    lpswValid = 1'b1; lpswSlot = 4'd2; cyc("R9 kept");
    // R4 restart lowest priority alone
    intReq = 6'b000001; cyc("R4"); cyc("R4");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(15) == 0) intReq = 6'($urandom_range(63));
      if ($urandom_range(9) == 0) begin lpswValid = 1'b1; lpswSlot = 4'($urandom_range(11)); end
      if ($urandom_range(4) == 0) begin brValid = 1'b1; brTarget = {$urandom, $urandom}; end
      if ($urandom_range(1) == 0) begin advValid = 1'b1; advLen = 3'(2 * $urandom_range(1, 3)); end
      if ($urandom_range(5) == 0) begin
        slotWrEn = 1'b1; slotWrAddr = 4'($urandom_range(11));
        slotWrData = {$urandom, $urandom, $urandom, $urandom};
      end
      cyc("");
    end
    finishRun();
  end
endmodule